// File: doc/BRIEF.md
# Nibble-Folding Lane Transmitter

This block takes a wide parallel word from a 10-gigabit media-independent interface and re-times it onto four narrow lanes that run at four times the word rate. Each word carries eight data bytes and eight control flags. Lane k serves byte k and byte k+4 of the word. Over four consecutive fast cycles each lane drives a 4-bit data group and one control line. For each byte the high nibble goes out first, then the low nibble. A byte's control flag is driven with its high nibble, and the control line is 0 while a low nibble is sent.

The whole design runs on the fast clock. A free-running 2-bit phase counter numbers the fast cycles 0 to 3. A load strobe offers a new word, and the block takes it only when the strobe is high during phase 3. The captured word then appears on the lanes starting at the next phase 0. A frame output is high on phase 0 so that a receiver can find word boundaries.

A bypass mode is sampled together with each word. In this mode each lane carries two 10-bit code groups instead of two bytes. Each group is sent as two 5-bit halves on consecutive fast cycles, and the control line serves as the fifth bit.

Top module: `nibble_fold_tx`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the phase is 0, `frame_o` is 1, and every bit of `lane_data_o` and `lane_ctrl_o` is 0.
- R2: The phase advances by one on every clock and wraps from 3 to 0. `frame_o` is 1 exactly on phase 0, so it is high on every fourth cycle.
- R3: A word is captured only when `load_i` is 1 during phase 3, and it is driven starting at the next phase 0. A high `load_i` during phases 0, 1 or 2 has no effect on the outputs.
- R4: Lane k drives `lane_data_o[4k+3:4k]` and `lane_ctrl_o[k]`. In phases 0 and 1 it carries byte k (`xg_data_i[8k+7:8k]`). In phases 2 and 3 it carries byte k+4 (`xg_data_i[8k+39:8k+32]`).
- R5: In normal mode, phases 0 and 2 carry bits [7:4] of the lane's byte, and phases 1 and 3 carry bits [3:0].
- R6: In normal mode, `lane_ctrl_o[k]` equals `xg_ctrl_i[k]` in phase 0 and `xg_ctrl_i[k+4]` in phase 2. It is 0 in phases 1 and 3.
- R7: In bypass mode, lane k carries group k (`code_i[10k+9:10k]`) in phases 0 and 1, and group k+4 (`code_i[10k+49:10k+40]`) in phases 2 and 3. Phases 0 and 2 send group bits [9:5] and phases 1 and 3 send bits [4:0]. Within each 5-bit half, bit 4 goes on `lane_ctrl_o[k]` and bits 3:0 go on the data nibble.
- R8: `bypass_i` is sampled only together with a captured word. Changing it at any other time does not alter the lane outputs of the word being sent.
- R9: If `load_i` is 0 during phase 3, the previously captured word is sent again unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Strobe offering a new word, taken in phase 3 |
| bypass_i | input | 1 | 1 selects 10-bit code group mode for the offered word |
| xg_data_i | input | 64 | Eight data bytes, byte n at bits [8n+7:8n] |
| xg_ctrl_i | input | 8 | Control flag n for byte n |
| code_i | input | 80 | Eight 10-bit code groups, group n at bits [10n+9:10n] |
| lane_data_o | output | 16 | Four 4-bit lane data groups |
| lane_ctrl_o | output | 4 | One control line per lane |
| frame_o | output | 1 | High on phase 0 |

## Verification
Capturing a new word and sending the last low nibble of the previous word happen in the same cycle (phase 3). The bench asserts `load_i` exactly in phase 3 with input values that differ from the word still on the lanes. A cycle-by-cycle model then confirms that phase 3 still shows the old word's low nibble and that the next phase 0 shows the new word's high nibble. The bench also keeps `load_i` high or toggles `bypass_i` during phases 0 to 2 with unrelated data, and it judges these by comparing every lane output against the model on every cycle.

// File: rtl/nft_pkg.sv
package nft_pkg;

    typedef enum logic [1:0] {
        PH_HI_A = 2'd0,
        PH_LO_A = 2'd1,
        PH_HI_B = 2'd2,
        PH_LO_B = 2'd3
    } phase_e;

endpackage

// File: rtl/nft_phase_ctr.sv
module nft_phase_ctr
    import nft_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o
);

    typedef struct packed {
        phase_e ph;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [1:0] nxt;

    always_comb begin
        nxt      = ctr_q.ph + 2'd1;
        ctr_d.ph = phase_e'(nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '{ph: PH_HI_A};
        else        ctr_q <= ctr_d;
    end

    assign phase_o = ctr_q.ph;

endmodule

// File: rtl/nft_word_hold.sv
module nft_word_hold #(
    parameter int LANES = 4,
    parameter int NIB_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cap_i,
    input  logic                           bypass_i,
    input  logic [2*LANES*2*NIB_W-1:0]     data_i,
    input  logic [2*LANES-1:0]             ctrl_i,
    input  logic [2*LANES*2*(NIB_W+1)-1:0] code_i,
    output logic                           bypass_o,
    output logic [2*LANES*2*NIB_W-1:0]     data_o,
    output logic [2*LANES-1:0]             ctrl_o,
    output logic [2*LANES*2*(NIB_W+1)-1:0] code_o
);

    localparam int WORD_W = 2 * LANES * 2 * NIB_W;
    localparam int CODE_T = 2 * LANES * 2 * (NIB_W + 1);

    typedef struct packed {
        logic                byp;
        logic [WORD_W-1:0]   data;
        logic [2*LANES-1:0]  ctrl;
        logic [CODE_T-1:0]   code;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap_i) begin
            hold_d.byp  = bypass_i;
            hold_d.data = data_i;
            hold_d.ctrl = ctrl_i;
            hold_d.code = code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign bypass_o = hold_q.byp;
    assign data_o   = hold_q.data;
    assign ctrl_o   = hold_q.ctrl;
    assign code_o   = hold_q.code;

endmodule

// File: rtl/nft_lane_mux.sv
module nft_lane_mux
    import nft_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  phase_e                 phase_i,
    input  logic                   bypass_i,
    input  logic [2*NIB_W-1:0]     byte_a_i,
    input  logic [2*NIB_W-1:0]     byte_b_i,
    input  logic                   ctl_a_i,
    input  logic                   ctl_b_i,
    input  logic [2*(NIB_W+1)-1:0] grp_a_i,
    input  logic [2*(NIB_W+1)-1:0] grp_b_i,
    output logic [NIB_W-1:0]       nib_o,
    output logic                   ctl_o
);

    localparam int BYTE_W = 2 * NIB_W;
    localparam int HALF_W = NIB_W + 1;
    localparam int CODE_W = 2 * HALF_W;

    logic              second;
    logic              low;
    logic [BYTE_W-1:0] byte_s;
    logic              ctl_s;
    logic [CODE_W-1:0] grp_s;
    logic [HALF_W-1:0] half_s;

    always_comb begin
        second = phase_i[1];
        low    = phase_i[0];
        byte_s = second ? byte_b_i : byte_a_i;
        ctl_s  = second ? ctl_b_i  : ctl_a_i;
        grp_s  = second ? grp_b_i  : grp_a_i;
        half_s = low ? grp_s[HALF_W-1:0] : grp_s[CODE_W-1:HALF_W];
        if (bypass_i) begin
            nib_o = half_s[NIB_W-1:0];
            ctl_o = half_s[NIB_W];
        end else begin
            nib_o = low ? byte_s[NIB_W-1:0] : byte_s[BYTE_W-1:NIB_W];
            ctl_o = low ? 1'b0 : ctl_s;
        end
    end

endmodule

// File: rtl/nibble_fold_tx.sv
module nibble_fold_tx
    import nft_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NIB_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_i,
    input  logic                           bypass_i,
    input  logic [2*LANES*2*NIB_W-1:0]     xg_data_i,
    input  logic [2*LANES-1:0]             xg_ctrl_i,
    input  logic [2*LANES*2*(NIB_W+1)-1:0] code_i,
    output logic [LANES*NIB_W-1:0]         lane_data_o,
    output logic [LANES-1:0]               lane_ctrl_o,
    output logic                           frame_o
);

    localparam int BYTE_W = 2 * NIB_W;
    localparam int CODE_W = 2 * (NIB_W + 1);
    localparam int WORD_W = 2 * LANES * BYTE_W;
    localparam int CODE_T = 2 * LANES * CODE_W;

    phase_e              phase;
    logic                cap;
    logic                byp_q;
    logic [WORD_W-1:0]   data_q;
    logic [2*LANES-1:0]  ctrl_q;
    logic [CODE_T-1:0]   code_q;

    nft_phase_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    // new word only on the last fast cycle of the frame
    assign cap = load_i && (phase == PH_LO_B);

    nft_word_hold #(.LANES(LANES), .NIB_W(NIB_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .bypass_i (bypass_i),
        .data_i   (xg_data_i),
        .ctrl_i   (xg_ctrl_i),
        .code_i   (code_i),
        .bypass_o (byp_q),
        .data_o   (data_q),
        .ctrl_o   (ctrl_q),
        .code_o   (code_q)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        nft_lane_mux #(.NIB_W(NIB_W)) u_lane (
            .phase_i  (phase),
            .bypass_i (byp_q),
            .byte_a_i (data_q[k*BYTE_W +: BYTE_W]),
            .byte_b_i (data_q[(k+LANES)*BYTE_W +: BYTE_W]),
            .ctl_a_i  (ctrl_q[k]),
            .ctl_b_i  (ctrl_q[k+LANES]),
            .grp_a_i  (code_q[k*CODE_W +: CODE_W]),
            .grp_b_i  (code_q[(k+LANES)*CODE_W +: CODE_W]),
            .nib_o    (lane_data_o[k*NIB_W +: NIB_W]),
            .ctl_o    (lane_ctrl_o[k])
        );
    end

    assign frame_o = (phase == PH_HI_A);

endmodule

// File: rtl/nft_checker.sv
module nft_checker #(
    parameter int LANES = 4,
    parameter int NIB_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       load_i,
    input logic                       bypass_i,
    input logic [2*LANES*2*NIB_W-1:0] xg_data_i,
    input logic [2*LANES-1:0]         xg_ctrl_i,
    input logic [LANES*NIB_W-1:0]     lane_data_o,
    input logic [LANES-1:0]           lane_ctrl_o,
    input logic                       frame_o
);

    localparam int BYTE_W = 2 * NIB_W;

    logic [1:0] cnt_q;
    logic       rpt_q;
    logic       byp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
            rpt_q <= 1'b0;
            byp_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 2'd1;
            if (cnt_q == 2'd3) begin
                rpt_q <= !load_i;
                if (load_i) byp_q <= bypass_i;
            end
        end
    end

    // R1
    a_r1_frame_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> frame_o && lane_ctrl_o == '0 && lane_data_o == '0);

    // R2
    a_r2_frame_every_fourth: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o == (cnt_q == 2'd0));

    // R3 / R5 / R6
    a_r3_capture_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 2'd3 && load_i && !bypass_i) |=>
            (lane_data_o[NIB_W-1:0] == $past(xg_data_i[BYTE_W-1:NIB_W])
             && lane_ctrl_o[0] == $past(xg_ctrl_i[0])));

    // R6
    a_r6_ctrl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[0] && !byp_q) |-> lane_ctrl_o == '0);

    // R9
    a_r9_repeat_word: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_q |-> (lane_data_o == $past(lane_data_o, 4)
                   && lane_ctrl_o == $past(lane_ctrl_o, 4)));

endmodule

bind nibble_fold_tx nft_checker #(.LANES(LANES), .NIB_W(NIB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .bypass_i    (bypass_i),
    .xg_data_i   (xg_data_i),
    .xg_ctrl_i   (xg_ctrl_i),
    .lane_data_o (lane_data_o),
    .lane_ctrl_o (lane_ctrl_o),
    .frame_o     (frame_o)
);

// File: tb/nibble_fold_tx_bench.sv
module nibble_fold_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        bypass_i = 1'b0;
    logic [63:0] xg_data_i = '0;
    logic [7:0]  xg_ctrl_i = '0;
    logic [79:0] code_i = '0;
    logic [15:0] lane_data_o;
    logic [3:0]  lane_ctrl_o;
    logic        frame_o;

    nibble_fold_tx u_nibble_fold_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .bypass_i    (bypass_i),
        .xg_data_i   (xg_data_i),
        .xg_ctrl_i   (xg_ctrl_i),
        .code_i      (code_i),
        .lane_data_o (lane_data_o),
        .lane_ctrl_o (lane_ctrl_o),
        .frame_o     (frame_o)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    int ph = 0;
    int ref_byp = 0;
    logic [15:0] exp_d [4];
    logic [3:0]  exp_c [4];
    string scen = "R4";

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // reference: rebuild the four beats of a word from the requirement text
    task automatic build_beats(input logic [63:0] d, input logic [7:0] c,
                               input logic [79:0] g, input logic byp);
        for (int b = 0; b < 4; b++) begin
            exp_d[b] = '0;
            exp_c[b] = '0;
            for (int k = 0; k < 4; k++) begin
                int src = (b < 2) ? k : k + 4;
                if (byp) begin
                    logic [9:0] grp = g[src*10 +: 10];
                    logic [4:0] half = (b % 2 == 1) ? grp[4:0] : grp[9:5];
                    exp_d[b][k*4 +: 4] = half[3:0];
                    exp_c[b][k] = half[4];
                end else begin
                    logic [7:0] by = d[src*8 +: 8];
                    exp_d[b][k*4 +: 4] = (b % 2 == 1) ? by[3:0] : by[7:4];
                    exp_c[b][k] = (b % 2 == 1) ? 1'b0 : c[src];
                end
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            ph = 0;
            for (int b = 0; b < 4; b++) begin
                exp_d[b] = '0;
                exp_c[b] = '0;
            end
        end else begin
            if (ph == 3 && load_i) begin
                build_beats(xg_data_i, xg_ctrl_i, code_i, bypass_i);
                ref_byp = int'(bypass_i);
            end
            ph = (ph + 1) % 4;
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (frame_o !== (ph == 0)) begin
                n_bad++;
                $display("FAIL R2 [%s] phase %0d frame got %b expected %b", scen, ph, frame_o, ph == 0);
            end
            n_cmp++;
            if (lane_data_o !== exp_d[ph]) begin
                n_bad++;
                $display("FAIL %s [%s] phase %0d data got %h expected %h",
                         ref_byp != 0 ? "R7" : "R4/R5", scen, ph, lane_data_o, exp_d[ph]);
            end
            n_cmp++;
            if (lane_ctrl_o !== exp_c[ph]) begin
                n_bad++;
                $display("FAIL %s [%s] phase %0d ctrl got %b expected %b",
                         ref_byp != 0 ? "R7" : "R6", scen, ph, lane_ctrl_o, exp_c[ph]);
            end
        end
    end

    task automatic wait_phase(input int p);
        @(negedge clk);
        while (ph != p) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] d, input logic [7:0] c,
                        input logic [79:0] g, input logic byp);
        wait_phase(3);
        xg_data_i = d;
        xg_ctrl_i = c;
        code_i    = g;
        bypass_i  = byp;
        load_i    = 1'b1;
        @(negedge clk);
        load_i    = 1'b0;
        xg_data_i = ~d;
        xg_ctrl_i = ~c;
        code_i    = ~g;
    endtask

    function automatic logic [79:0] rnd_code();
        logic [95:0] t = {$urandom, $urandom, $urandom};
        return t[79:0];
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen on the first cycle after release
        rst_n = 1'b1;
        #1;
        n_cmp++;
        if (frame_o !== 1'b1 || lane_data_o !== '0 || lane_ctrl_o !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: got frame %b data %h ctrl %b expected 1 0000 0000",
                     frame_o, lane_data_o, lane_ctrl_o);
        end

        scen = "R4 fixed";
        send(64'h0123_4567_89AB_CDEF, 8'hA5, '0, 1'b0);
        send(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, '0, 1'b0);
        send(64'h0, 8'h0, '0, 1'b0);
        scen = "R5 random";
        for (int i = 0; i < 20; i++)
            send({$urandom, $urandom}, 8'($urandom), rnd_code(), 1'b0);

        scen = "R7 bypass";
        send('0, '0, {8{10'b10_0001_1110}}, 1'b1);
        for (int i = 0; i < 20; i++)
            send({$urandom, $urandom}, 8'($urandom), rnd_code(), 1'b1);

        // R3: strobe held in phases 0..2 with other data must be ignored
        scen = "R3 stray load";
        send(64'hDEAD_BEEF_0BAD_F00D, 8'h3C, rnd_code(), 1'b0);
        for (int i = 0; i < 3; i++) begin
            wait_phase(i);
            load_i    = 1'b1;
            xg_data_i = {$urandom, $urandom};
            xg_ctrl_i = 8'($urandom);
        end
        wait_phase(3);
        load_i = 1'b0;
        repeat (6) @(negedge clk);

        // R8: mode change mid-word has no effect
        scen = "R8 mode toggle";
        send('0, '0, rnd_code(), 1'b1);
        for (int i = 0; i < 3; i++) begin
            wait_phase(i);
            bypass_i = 1'b0;
        end
        send(64'h1122_3344_5566_7788, 8'h81, rnd_code(), 1'b0);
        for (int i = 0; i < 3; i++) begin
            wait_phase(i);
            bypass_i = 1'b1;
        end

        // R9: idle frames repeat the last word
        scen = "R9 repeat";
        wait_phase(3);
        repeat (16) @(negedge clk);

        // back-to-back mixed modes
        scen = "R3 back-to-back";
        for (int i = 0; i < 16; i++)
            send({$urandom, $urandom}, 8'($urandom), rnd_code(), 1'($urandom));
        repeat (8) @(negedge clk);
        finish_run();
    end

endmodule